// File: doc/BRIEF.md
# Symmetric Glitch-Rejection Input Filter

This block cleans up one logic control line, such as a high-side or low-side gate command or a global enable, before the line reaches the rest of a gate-drive controller. It first brings the raw line into the clock domain through a chain of flip-flops. It then qualifies every change of level. The filtered output takes a new level only after the synchronized input has stayed at that level for a whole filter window, counted in clock cycles.

Both edges go through the same synchronizer and the same qualification window. Because of this, a pulse that survives the filter leaves the block with the width it had on entry, only shifted in time. Short excursions are discarded in both directions: high spikes on a low line and low dropouts on a high line. A burst of such spikes has no effect, because each return to the current output level restarts the window.

The filter window is a parameter in clock cycles and must be at least 2. For example, 63 cycles at 250 MHz gives roughly 250 ns. The number of synchronizer stages is also a parameter, with a minimum of 2. Reset drives the output low, which is the inactive level.

Top module: `glitch_filter`

## Requirements
- R1: While rst_n is low, filt_o is 0, whatever raw_i does, and asserting rst_n clears a high output at once.
- R2: When raw_i goes from 0 to 1 and stays at 1, filt_o rises exactly FILT_CYCLES + SYNC_STAGES clock edges after the first edge that samples the 1.
- R3: When raw_i goes from 1 to 0 and stays at 0, filt_o falls after the same number of edges as in R2, so both edges see equal latency.
- R4: A pulse on raw_i that is sampled at the opposite level on N consecutive edges, with N >= FILT_CYCLES, appears on filt_o with a width of exactly N cycles.
- R5: A high pulse on a low line that lasts fewer than FILT_CYCLES sampled cycles leaves filt_o at 0.
- R6: A low pulse on a high line that lasts fewer than FILT_CYCLES sampled cycles leaves filt_o at 1.
- R7: A train of spikes, each shorter than FILT_CYCLES and separated by gaps as short as one cycle at the output level, leaves filt_o unchanged. Each return to the output level restarts the qualification.
- R8: filt_o changes only when the synchronized input has held the new level on at least FILT_CYCLES consecutive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and filter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| raw_i | input | 1 | Unfiltered logic line; may be asynchronous to clk |
| filt_o | output | 1 | Qualified level, 0 after reset |

## Verification
Pulses of opposite polarity are applied from both settled levels:
- Widths of exactly the window, slightly above it and well above it separate the correct pass threshold and width preservation from an off-by-one in the counter or the latency.
- Widths of one cycle and of one cycle short of the window confirm rejection at the boundary in both directions.
- Spike trains with one-cycle gaps tell apart a counter that restarts from one that keeps accumulating across glitches.
- Assertion of reset while the output is high confirms the asynchronous clear.

// File: rtl/glf_pkg.sv
package glf_pkg;

  // Width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned glf_idx_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n);
    if (w < 1) w = 1;
    return w;
  endfunction

  // Qualifier condition for the current cycle.
  typedef enum logic [1:0] {
    QS_MATCH   = 2'b00,  // synchronized level equals output
    QS_COUNT   = 2'b01,  // differing level, window still open
    QS_COMMIT  = 2'b10   // differing level held for the whole window
  } qual_state_e;

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = d_i;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_d[s];
      end

      // Every stage delays by exactly one edge, for both polarities.
      AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (chain_q[s] == $past(chain_d[s])))
        else $error("stage shift broken"); // R3
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/glf_qualify.sv
module glf_qualify
  import glf_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic filt_o
);

  localparam int unsigned CNT_W = glf_idx_width(FILT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);
  localparam int unsigned RUN_W = glf_idx_width(FILT_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(FILT_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             out_q, out_d;
  logic             out_en;
  qual_state_e      qstate;

  // Classify the present cycle.
  always_comb begin
    if (lvl_i == out_q)         qstate = QS_MATCH;
    else if (cnt_q == CNT_LAST) qstate = QS_COMMIT;
    else                        qstate = QS_COUNT;
  end

  // Next-state logic.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    out_d  = out_q;
    out_en = 1'b0;
    unique case (qstate)
      QS_MATCH: begin
        cnt_d  = '0;
        cnt_en = (cnt_q != '0);
      end
      QS_COUNT: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
      QS_COMMIT: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
        out_d  = lvl_i;
        out_en = 1'b1;
      end
      default: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    endcase
  end

  // Registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (out_en) out_q <= out_d;
  end

  assign filt_o = out_q;

  // ---------------- assertions ----------------
  // Independent run-length monitor of the synchronized level.
  logic [RUN_W-1:0] run_q;
  logic             lvl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_prev_q <= lvl_i;
      if (lvl_i != lvl_prev_q)  run_q <= RUN_W'(1);
      else if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST) else $error("counter out of range"); // R8

  AST_FLIP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ((run_q >= RUN_FULL) && (out_q == $past(lvl_i))))
    else $error("output moved without a full window"); // R8

  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == out_q) |=> $stable(out_q))
    else $error("output moved while input matched"); // R7

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_LOW: assert (out_q == 1'b0) else $error("output high in reset"); // R1
    end
  end

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int unsigned FILT_CYCLES = 63,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);

  logic lvl_sync;

  glf_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_i),
    .q_o   (lvl_sync)
  );

  glf_qualify #(
    .FILT_CYCLES (FILT_CYCLES)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_sync),
    .filt_o (filt_o)
  );

endmodule

// File: tb/tb_glitch_filter.sv
`timescale 1ns/1ps
module tb_glitch_filter;

  localparam int FILT = 12;
  localparam int SYNC = 2;
  localparam int LAT  = FILT + SYNC;

  logic clk = 1'b0;
  logic rst_n;
  logic raw_i;
  logic filt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  glitch_filter #(.FILT_CYCLES(FILT), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .filt_o(filt_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Hold a level long enough to settle, then confirm the output follows.
  task automatic settle(input logic lvl, input string req);
    @(negedge clk);
    raw_i = lvl;
    repeat (LAT + 6) @(negedge clk);
    check(filt_o === lvl, req, "settled level", int'(filt_o), int'(lvl));
  endtask

  // One pulse of the opposite level, width given in sampled cycles.
  task automatic run_pulse(input logic base, input int width, input bit expect_pass);
    int first_at  = -1;
    int second_at = -1;
    int total     = width + LAT + 8;
    string t1 = base ? "R3" : "R2";
    string t2 = base ? "R2" : "R3";
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (first_at < 0 && filt_o !== base) first_at = i;
      else if (first_at >= 0 && second_at < 0 && filt_o === base) second_at = i;
      raw_i = (i < width) ? ~base : base;
    end
    if (expect_pass) begin
      check(first_at == LAT, t1, "first edge latency", first_at, LAT);
      check(second_at == width + LAT, t2, "second edge latency", second_at, width + LAT);
      check(second_at - first_at == width, "R4", "pulse width", second_at - first_at, width);
    end else begin
      check(first_at == -1, base ? "R6" : "R5", "short pulse rejected", first_at, -1);
    end
  endtask

  // Spikes of a given width separated by gaps at the base level.
  task automatic run_train(input logic base, input int spike, input int gap, input int count);
    int moves = 0;
    for (int k = 0; k < count; k++) begin
      for (int j = 0; j < spike + gap; j++) begin
        @(negedge clk);
        if (filt_o !== base) moves++;
        raw_i = (j < spike) ? ~base : base;
      end
    end
    repeat (LAT + 4) begin
      @(negedge clk);
      if (filt_o !== base) moves++;
    end
    check(moves == 0, "R7", "spike train cycles off base", moves, 0);
  endtask

  task automatic reset_tests();
    raw_i = 1'b1;
    rst_n = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(filt_o === 1'b0, "R1", "output in reset with input high", int'(filt_o), 0);
    rst_n = 1'b1;
    settle(1'b1, "R2");
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5;
    check(filt_o === 1'b0, "R1", "async clear of high output", int'(filt_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    raw_i = 1'b0;
    reset_tests();
    settle(1'b0, "R3");
    // high pulses on a low line
    run_pulse(1'b0, FILT, 1'b1);
    run_pulse(1'b0, FILT + 5, 1'b1);
    run_pulse(1'b0, 40, 1'b1);
    run_pulse(1'b0, FILT - 1, 1'b0);
    run_pulse(1'b0, 1, 1'b0);
    run_train(1'b0, FILT - 1, 1, 6);
    run_train(1'b0, 2, 3, 8);
    // low pulses on a high line
    settle(1'b1, "R2");
    run_pulse(1'b1, FILT, 1'b1);
    run_pulse(1'b1, 20, 1'b1);
    run_pulse(1'b1, FILT - 1, 1'b0);
    run_pulse(1'b1, 1, 1'b0);
    run_train(1'b1, FILT - 1, 1, 6);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule